// File: doc/BRIEF.md
# Colored-Button Sequence Lock Controller

This controller guards a door latch behind a short button code. An operator first presses a start button. The controller then expects four colored presses in a fixed order: red, blue, green, red. A separate "some colored button is down" indicator tells it when a press is present. When the last correct press arrives, the controller asserts its unlock output for exactly one clock cycle. It then falls back to waiting for a new start.

A step advances only when the expected color is the only colored line high while the indicator is high. Any other combination with the indicator high sends the controller back to waiting without unlocking, and that includes several colors held at once. Cycles with the indicator low leave the current step alone, so an operator may pause between presses. The decision logic is built so that in every entry step exactly one outcome applies: hold, advance or abort.

The asynchronous active-low reset takes effect at once. Its release is synchronized to the clock through a configurable number of stages. Until the synchronized release arrives, the controller stays in its waiting state.

Top module: `code_lock_fsm`

## Requirements
- R1: While reset is asserted, and after any reset, the controller is in its waiting state with `unlock` = 0; a reset in the middle of an entry discards the partial code.
- R2: In the waiting state the controller stays put while `start_btn` is 0, whatever the colored and indicator lines do, and moves to the first entry step when `start_btn` is 1.
- R3: In any of the four entry steps, a cycle with `any_btn` = 0 keeps the step unchanged, whatever the colored lines show.
- R4: The code is red, blue, green, red, where the colored lines are red_btn, green_btn and blue_btn. After start and these four presses, `unlock` reads 1 in the cycle following the clock edge that captured the final red press, and never otherwise.
- R5: In an entry step, a single colored button other than the expected one, with `any_btn` = 1, returns the controller to the waiting state, and the rest of the code then does not unlock.
- R6: In an entry step, two or more colored lines high with `any_btn` = 1 count as a wrong press and return the controller to the waiting state, even when the expected color is among them.
- R7: `unlock` lasts one cycle; the controller then returns to the waiting state unconditionally, even if `start_btn` is held during the unlock cycle.
- R8: In every entry step, exactly one of hold, advance and abort applies in each cycle.
- R9: `start_btn` has no effect outside the waiting state; holding it during entry neither restarts nor disturbs the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| start_btn | input | 1 | Start button, begins a code entry |
| red_btn | input | 1 | Red button line |
| green_btn | input | 1 | Green button line |
| blue_btn | input | 1 | Blue button line |
| any_btn | input | 1 | High when a colored press is present |
| unlock | output | 1 | One-cycle unlock pulse after a correct code |

## Verification
The bench builds the controller with three reset-release stages instead of the default two. With that setting, a reset in the middle of an entry and the longer quiet window after release are covered, and the bench's model has to agree that no press counts until release has propagated. The stimulus covers several cases: a clean code, the code with pauses in which colored lines toggle while the indicator is low, every single wrong color at every step, and all buttons at once at every step. Start is also held through an entry and through the unlock cycle. Because every wrong-press case is followed by the rest of the code, an abort that failed to happen would show up as an unlock pulse the model does not expect.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int NUM_COLORS = 3;
  localparam int COL_W      = $clog2(NUM_COLORS);
  localparam int ST_W       = 3;

  typedef enum logic [COL_W-1:0] {
    COL_RED   = 2'd0,
    COL_GREEN = 2'd1,
    COL_BLUE  = 2'd2
  } color_e;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_K1    = 3'd2,
    ST_K2    = 3'd3,
    ST_K3    = 3'd4,
    ST_OPEN  = 3'd5
  } lock_state_e;

  typedef struct packed {
    logic hold;
    logic adv;
    logic abort;
  } step_t;

  // Color expected while sitting in a given entry step.
  function automatic color_e want_color(lock_state_e st);
    case (st)
      ST_ARMED: return COL_RED;
      ST_K1:    return COL_BLUE;
      ST_K2:    return COL_GREEN;
      ST_K3:    return COL_RED;
      default:  return COL_RED;
    endcase
  endfunction

  function automatic logic in_entry(lock_state_e st);
    return (st == ST_ARMED) || (st == ST_K1) || (st == ST_K2) || (st == ST_K3);
  endfunction

endpackage

// File: rtl/lock_press_decode.sv
module lock_press_decode
  import lock_pkg::*;
#(
  parameter int NCOL  = NUM_COLORS,
  parameter int SEL_W = $clog2(NCOL)
) (
  input  logic             any_btn,
  input  logic [NCOL-1:0]  col,
  input  logic [SEL_W-1:0] sel,
  output step_t            step
);

  // alone[i]: color i is high and no other colored line is high
  logic [NCOL-1:0] alone;

  for (genvar i = 0; i < NCOL; i++) begin : g_alone
    assign alone[i] = col[i] & ~|(col & ~(NCOL'(1) << i));
  end

  always_comb begin
    step.hold  = ~any_btn;
    step.adv   = any_btn & alone[sel];
    step.abort = any_btn & ~alone[sel];
  end

endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
(
  input  lock_state_e cur,
  input  logic        start_btn,
  input  step_t       step,
  output lock_state_e nxt
);

  function automatic lock_state_e succ(lock_state_e st);
    case (st)
      ST_ARMED: return ST_K1;
      ST_K1:    return ST_K2;
      ST_K2:    return ST_K3;
      ST_K3:    return ST_OPEN;
      default:  return ST_IDLE;
    endcase
  endfunction

  always_comb begin
    nxt = cur;
    case (cur)
      ST_IDLE: begin
        if (start_btn) nxt = ST_ARMED;
      end
      ST_ARMED, ST_K1, ST_K2, ST_K3: begin
        if (step.abort)    nxt = ST_IDLE;
        else if (step.adv) nxt = succ(cur);
        else               nxt = cur;
      end
      ST_OPEN: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg
  import lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  lock_state_e nxt,
  output lock_state_e cur,
  output logic        rst_sync_n
);

  logic [SYNC_STAGES-1:0] sync_q;

  if (SYNC_STAGES == 1) begin : g_sync_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= 1'b1;
    end
  end else begin : g_sync_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  logic load_en;
  assign load_en = (nxt != cur);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cur <= ST_IDLE;
    else if (load_en) cur <= nxt;
  end

endmodule

// File: rtl/code_lock_fsm.sv
module code_lock_fsm
  import lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_btn,
  input  logic red_btn,
  input  logic green_btn,
  input  logic blue_btn,
  input  logic any_btn,
  output logic unlock
);

  logic [NUM_COLORS-1:0] col;
  logic [COL_W-1:0]      sel;
  step_t                 step;
  lock_state_e           cur;
  lock_state_e           nxt;
  logic                  rst_sync_n;

  assign col = {blue_btn, green_btn, red_btn};
  assign sel = want_color(cur);

  lock_press_decode #(.NCOL(NUM_COLORS), .SEL_W(COL_W)) u_decode (
    .any_btn (any_btn),
    .col     (col),
    .sel     (sel),
    .step    (step)
  );

  lock_next_state u_next (
    .cur       (cur),
    .start_btn (start_btn),
    .step      (step),
    .nxt       (nxt)
  );

  lock_state_reg #(.SYNC_STAGES(SYNC_STAGES)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .nxt        (nxt),
    .cur        (cur),
    .rst_sync_n (rst_sync_n)
  );

  assign unlock = (cur == ST_OPEN);

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur == ST_IDLE && !start_btn) |=> (cur == ST_IDLE)); // R2

  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_entry(cur) && !any_btn) |=> $stable(cur)); // R3

  AST_UNLOCK_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unlock |-> ($past(cur) == ST_K3 &&
                $past(any_btn && red_btn && !green_btn && !blue_btn))); // R4

  AST_WRONG_ABORTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_entry(cur) && any_btn && $countones(col) == 1 && !col[sel])
      |=> (cur == ST_IDLE)); // R5

  AST_MULTI_ABORTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_entry(cur) && any_btn && $countones(col) > 1) |=> (cur == ST_IDLE)); // R6

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    unlock |=> (!unlock && cur == ST_IDLE)); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_entry(cur) |-> $onehot({step.hold, step.adv, step.abort})); // R8

endmodule

// File: tb/code_lock_fsm_bench.sv
module code_lock_fsm_bench;

  localparam int STAGES = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_btn = 1'b0;
  logic red_btn = 1'b0;
  logic green_btn = 1'b0;
  logic blue_btn = 1'b0;
  logic any_btn = 1'b0;
  logic unlock;

  int checks = 0;
  int errors = 0;
  int mstate = 0;           // 0 wait, 1..4 entry steps, 5 unlocked
  int code_seq[4] = '{0, 2, 1, 0};  // 0 red, 1 green, 2 blue

  always #4 clk = ~clk;

  code_lock_fsm #(.SYNC_STAGES(STAGES)) u_code_lock_fsm (
    .clk(clk), .rst_n(rst_n), .start_btn(start_btn), .red_btn(red_btn),
    .green_btn(green_btn), .blue_btn(blue_btn), .any_btn(any_btn),
    .unlock(unlock)
  );

  function automatic int model_next(int st, bit s, bit r, bit g, bit b, bit a);
    bit [2:0] cv;
    cv = {b, g, r};
    if (st == 0) return s ? 1 : 0;
    if (st == 5) return 0;
    if (!a) return st;
    if (cv == (3'b001 << code_seq[st-1])) return st + 1;
    return 0;
  endfunction

  task automatic check(input string tag);
    bit exp;
    exp = (mstate == 5);
    checks++;
    if (unlock !== exp) begin
      errors++;
      $display("FAIL %s: unlock=%0b expected=%0b", tag, unlock, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge, check after the next rise.
  task automatic press(input bit s, input bit r, input bit g, input bit b,
                       input bit a, input string tag);
    start_btn = s; red_btn = r; green_btn = g; blue_btn = b; any_btn = a;
    mstate = model_next(mstate, s, r, g, b, a);
    @(negedge clk);
    check(tag);
  endtask

  task automatic press_col(input int c, input bit s, input string tag);
    press(s, c == 0, c == 1, c == 2, 1'b1, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) press(0, 0, 0, 0, 0, tag);
  endtask

  task automatic prefix(input int n, input string tag);
    press(1, 0, 0, 0, 0, tag);
    for (int i = 0; i < n; i++) press_col(code_seq[i], 1'b0, tag);
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0;
    mstate = 0;
    #1;
    check(tag);
    idle(2, tag);
    rst_n = 1'b1;
    idle(STAGES + 2, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: unlock=%0b expected=finish", unlock);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset");
    idle(2, "R1 in reset");
    rst_n = 1'b1;
    idle(STAGES + 2, "R1 after release");

    // R2: colors ignored while waiting
    press(0, 1, 1, 1, 1, "R2 colors in wait");
    press(0, 1, 0, 0, 1, "R2 red in wait");
    prefix(4, "R4 clean code");
    idle(2, "R7 pulse ends");

    // R3: pauses with colored lines toggling while any_btn low
    press(1, 0, 0, 0, 0, "R3 start");
    for (int i = 0; i < 4; i++) begin
      press(0, 1, 1, 1, 0, "R3 gap lines high");
      idle(2, "R3 gap");
      press_col(code_seq[i], 1'b0, "R3 step");
    end
    idle(2, "R3 tail");

    // R5: each single wrong color at each step, then rest of code
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 3; c++) begin
        if (c != code_seq[k]) begin
          prefix(k, "R5 prefix");
          press_col(c, 1'b0, "R5 wrong color");
          for (int i = k; i < 4; i++) press_col(code_seq[i], 1'b0, "R5 no unlock");
          idle(1, "R5 idle");
        end
      end
    end

    // R6: all colors at once at each step
    for (int k = 0; k < 4; k++) begin
      prefix(k, "R6 prefix");
      press(0, 1, 1, 1, 1, "R6 all at once");
      for (int i = k; i < 4; i++) press_col(code_seq[i], 1'b0, "R6 no unlock");
      idle(1, "R6 idle");
    end
    // R6: expected color plus one other
    prefix(3, "R6 prefix pair");
    press(0, 1, 1, 0, 1, "R6 red and green");
    press_col(0, 1'b0, "R6 no unlock");
    idle(1, "R6 idle");

    // R9 and R7: start held through entry and through the unlock cycle
    press(1, 0, 0, 0, 0, "R9 start");
    for (int i = 0; i < 4; i++) press_col(code_seq[i], 1'b1, "R9 start held");
    press(1, 0, 0, 0, 0, "R7 start in unlock cycle");
    press(0, 0, 0, 0, 0, "R7 back to wait");
    press_col(0, 1'b0, "R7 red ignored in wait");
    idle(1, "R7 idle");

    // R1: reset in the middle of an entry
    prefix(3, "R1 partial");
    do_reset("R1 mid-entry reset");
    press_col(0, 1'b0, "R1 partial discarded");
    idle(1, "R1 idle");
    prefix(4, "R1 code after reset");
    idle(2, "R1 done");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule